// File: doc/BRIEF.md
# Serial Link Pin-Mode Multiplexer

This block sits between a serial link controller and two shared port pins, plus a third pin that can carry an external clock. It decides which signal drives each pin. It decides whether each pin's driver is enabled. It decides which pin's input returns to the controller as received data. When the serial function does not claim the pins, they behave as ordinary port pins that follow their latch bits.

When the serial function is enabled, a mode bit picks one of two pairings:

- **Half-duplex pairing.** The data pin carries both transmit and receive. The other pin announces which way data is flowing.
- **Full-duplex pairing.** One pin is a dedicated receive input and the other is a dedicated transmit output.

Clearing the data pin's latch bit while the serial function is enabled selects a diagnostic mode. In that mode the controller's transmit stream is fed straight back to its receive input.

The pin drive values and enables are registered, so a mode change never glitches a pin. Any new setting appears on the pins after the next clock edge. Every pin input passes through a two-flop synchronizer before it is used.

Top module: `sio_pin_mux`

## Requirements
- R1: While `rst_n` is low, the outputs are: `pad_oe`=2'b11, `pad_o`=2'b11, `rx_data`=1, `ext_clk`=0 and `pad_rd`=2'b00.
- R2: With `serial_en`=0 (port mode), one edge after the inputs are sampled `pad_o` equals `port_latch` and `pad_oe`=2'b11. In this mode `rx_data` rests at 1, and `pad_rd` shows `pad_i` two clock edges later.
- R3: In half-duplex mode (`serial_en`=1, `port_latch[1]`=1, `loop_sel`=0), one edge after sampling:
  - pin 0 is driven (`pad_oe[0]`=1) with the value of `tx_en`, which is 1 while transmitting and 0 while receiving;
  - pin 1 carries `tx_data` on `pad_o[1]`, and its enable `pad_oe[1]` equals `tx_en`.
- R4: In half-duplex mode, `rx_data` equals `pad_i[1]` two clock edges after it is applied.
- R5: In full-duplex mode (`serial_en`=1, `port_latch[1]`=1, `loop_sel`=1), one edge after sampling:
  - `pad_oe`=2'b10, `pad_o[0]`=0 and `pad_o[1]`=`tx_data`;
  - `rx_data` equals `pad_i[0]` two edges after it is applied.
- R6: Diagnostic mode is `serial_en`=1 with `port_latch[1]`=0, whatever the value of `loop_sel`. In this mode:
  - `pad_oe`=2'b10 and `pad_o`=2'b00;
  - `rx_data` equals `tx_data` as sampled at the previous edge, and `pad_i` has no effect on it.
- R7: While the serial function is enabled, `port_latch[0]` has no effect on the pin outputs.
- R8: A change of `serial_en`, `loop_sel` or `port_latch` leaves `pad_o` and `pad_oe` unchanged until the next rising clock edge, and takes full effect at that edge.
- R9: When `clk_src_sel`=1, `ext_clk` equals `ck_pad_i` two edges after it is applied. When `clk_src_sel`=0, `ext_clk` is 0 within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_latch | input | 2 | Port latch bits for pin 0 and pin 1 |
| serial_en | input | 1 | Serial function claims the two pins |
| loop_sel | input | 1 | 0: half-duplex data plus direction; 1: separate receive and transmit pins |
| tx_data | input | 1 | Transmit data from the controller |
| tx_en | input | 1 | Controller is transmitting |
| clk_src_sel | input | 1 | Controller selects the external clock pin |
| pad_i | input | 2 | Pin input buffers |
| ck_pad_i | input | 1 | External clock pin input |
| pad_o | output | 2 | Registered pin drive values |
| pad_oe | output | 2 | Registered pin output enables |
| rx_data | output | 1 | Received data returned to the controller |
| ext_clk | output | 1 | Synchronized external clock returned to the controller |
| pad_rd | output | 2 | Synchronized pin read-back for port use |

## Verification
The assertions check the per-mode pin pairing on every cycle, against the registered mode:

- the direction pin agrees with the data pin's enable in half-duplex mode;
- the full-duplex and diagnostic enable patterns hold, and the transmit bit lands on pin 1;
- the diagnostic loop of `tx_data` into `rx_data` holds;
- the port pins follow the latch;
- the external clock is held low when it is not selected.

Only the bench scenarios can show the following:

- the two-edge synchronizer latency on received data, read-back and the clock;
- that pin inputs are ignored in diagnostic mode;
- that a mode change waits for the next edge.

// File: rtl/sio_pin_pkg.sv
package sio_pin_pkg;

  typedef enum logic [1:0] {
    PM_GPIO = 2'd0,
    PM_HALF = 2'd1,
    PM_FULL = 2'd2,
    PM_DIAG = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic [1:0] drv;
    logic [1:0] oe;
  } pad_ctl_t;

  // Diagnostic selection wins over the pairing bit.
  function automatic pin_mode_e pick_mode(input logic serial_en,
                                          input logic loop_sel,
                                          input logic data_latch);
    pin_mode_e m;
    if (!serial_en)       m = PM_GPIO;
    else if (!data_latch) m = PM_DIAG;
    else if (loop_sel)    m = PM_FULL;
    else                  m = PM_HALF;
    return m;
  endfunction

  function automatic pad_ctl_t pad_ctl(input pin_mode_e m,
                                       input logic [1:0] latch,
                                       input logic txd,
                                       input logic tx_en);
    pad_ctl_t r;
    case (m)
      PM_HALF: begin r.drv = {txd, tx_en};        r.oe = {tx_en, 1'b1}; end
      PM_FULL: begin r.drv = {txd, 1'b0};         r.oe = 2'b10;         end
      PM_DIAG: begin r.drv = {latch[1], 1'b0};    r.oe = 2'b10;         end
      default: begin r.drv = latch;               r.oe = 2'b11;         end
    endcase
    return r;
  endfunction

  function automatic logic rx_pick(input pin_mode_e m,
                                   input logic [1:0] pin_s,
                                   input logic txd_loop);
    logic r;
    case (m)
      PM_HALF: r = pin_s[1];
      PM_FULL: r = pin_s[0];
      PM_DIAG: r = txd_loop;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/sio_pin_drive.sv
module sio_pin_drive
  import sio_pin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode_d,
  input  logic [1:0] latch,
  input  logic      txd,
  input  logic      tx_en,
  output logic [1:0] pad_o,
  output logic [1:0] pad_oe,
  output pin_mode_e mode_q,
  output logic      txd_q
);
  pad_ctl_t nxt;

  always_comb nxt = pad_ctl(mode_d, latch, txd, tx_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_o  <= 2'b11;
      pad_oe <= 2'b11;
      mode_q <= PM_GPIO;
      txd_q  <= 1'b0;
    end else begin
      pad_o  <= nxt.drv;
      pad_oe <= nxt.oe;
      mode_q <= mode_d;
      txd_q  <= txd;
    end
  end
endmodule

// File: rtl/sio_rx_sel.sv
module sio_rx_sel
  import sio_pin_pkg::*;
(
  input  pin_mode_e  mode_q,
  input  logic [1:0] pin_s,
  input  logic       txd_q,
  input  logic       ck_s,
  input  logic       clk_src_sel,
  output logic       rx_data,
  output logic       ext_clk
);
  always_comb begin
    rx_data = rx_pick(mode_q, pin_s, txd_q);
    ext_clk = clk_src_sel & ck_s;
  end
endmodule

// File: rtl/sio_pin_mux.sv
module sio_pin_mux
  import sio_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] port_latch,
  input  logic       serial_en,
  input  logic       loop_sel,
  input  logic       tx_data,
  input  logic       tx_en,
  input  logic       clk_src_sel,
  input  logic [1:0] pad_i,
  input  logic       ck_pad_i,
  output logic [1:0] pad_o,
  output logic [1:0] pad_oe,
  output logic       rx_data,
  output logic       ext_clk,
  output logic [1:0] pad_rd
);
  localparam int SYNC_W = 3;

  pin_mode_e         mode_d;
  pin_mode_e         mode_q;
  logic              txd_q;
  logic [SYNC_W-1:0] sync_q;

  always_comb mode_d = pick_mode(serial_en, loop_sel, port_latch[1]);

  sio_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ck_pad_i, pad_i}),
    .q     (sync_q)
  );

  sio_pin_drive u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_d (mode_d),
    .latch  (port_latch),
    .txd    (tx_data),
    .tx_en  (tx_en),
    .pad_o  (pad_o),
    .pad_oe (pad_oe),
    .mode_q (mode_q),
    .txd_q  (txd_q)
  );

  sio_rx_sel u_rx (
    .mode_q      (mode_q),
    .pin_s       (sync_q[1:0]),
    .txd_q       (txd_q),
    .ck_s        (sync_q[2]),
    .clk_src_sel (clk_src_sel),
    .rx_data     (rx_data),
    .ext_clk     (ext_clk)
  );

  assign pad_rd = sync_q[1:0];
endmodule

// File: rtl/sio_pin_mux_chk.sv
module sio_pin_mux_chk
  import sio_pin_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input pin_mode_e  mode_q,
  input logic [1:0] port_latch,
  input logic       tx_data,
  input logic       clk_src_sel,
  input logic [1:0] pad_o,
  input logic [1:0] pad_oe,
  input logic       rx_data,
  input logic       ext_clk
);
  // R2
  gpio_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_GPIO && $past(rst_n)) |-> (pad_oe == 2'b11 && pad_o == $past(port_latch) && rx_data));

  // R3
  half_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_HALF) |-> (pad_oe[0] && pad_o[0] == pad_oe[1]));

  // R3
  half_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_HALF && pad_oe[1]) |-> (pad_o[1] == $past(tx_data)));

  // R5
  full_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_FULL) |-> (pad_oe == 2'b10 && !pad_o[0] && pad_o[1] == $past(tx_data)));

  // R6
  diag_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_DIAG) |-> (pad_oe == 2'b10 && pad_o == 2'b00 && rx_data == $past(tx_data)));

  // R9
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_src_sel |-> !ext_clk);
endmodule

bind sio_pin_mux sio_pin_mux_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_q      (mode_q),
  .port_latch  (port_latch),
  .tx_data     (tx_data),
  .clk_src_sel (clk_src_sel),
  .pad_o       (pad_o),
  .pad_oe      (pad_oe),
  .rx_data     (rx_data),
  .ext_clk     (ext_clk)
);

// File: tb/test_sio_pin_mux.sv
`timescale 1ns/1ps
module test_sio_pin_mux;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] port_latch;
  logic       serial_en, loop_sel, tx_data, tx_en, clk_src_sel;
  logic [1:0] pad_i;
  logic       ck_pad_i;
  logic [1:0] pad_o, pad_oe, pad_rd;
  logic       rx_data, ext_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sio_pin_mux i_sio_pin_mux (
    .clk(clk), .rst_n(rst_n), .port_latch(port_latch), .serial_en(serial_en),
    .loop_sel(loop_sel), .tx_data(tx_data), .tx_en(tx_en), .clk_src_sel(clk_src_sel),
    .pad_i(pad_i), .ck_pad_i(ck_pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .rx_data(rx_data), .ext_clk(ext_clk), .pad_rd(pad_rd)
  );

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic edge2();
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; port_latch = 2'b11; serial_en = 0; loop_sel = 0;
    tx_data = 0; tx_en = 0; clk_src_sel = 0; pad_i = 2'b11; ck_pad_i = 1;
    repeat (3) @(posedge clk); #1;
    chk("R1", "pad_oe", {2'b0, pad_oe}, 4'h3);
    chk("R1", "pad_o", {2'b0, pad_o}, 4'h3);
    chk("R1", "rx_data", {3'b0, rx_data}, 4'h1);
    chk("R1", "ext_clk", {3'b0, ext_clk}, 4'h0);
    chk("R1", "pad_rd", {2'b0, pad_rd}, 4'h0);
    @(negedge clk); rst_n = 1'b1; pad_i = 2'b00; ck_pad_i = 0;
  endtask

  task automatic t_gpio();
    @(negedge clk); serial_en = 0; port_latch = 2'b01;
    edge1();
    chk("R2", "pad_o latch 01", {2'b0, pad_o}, 4'h1);
    chk("R2", "pad_oe", {2'b0, pad_oe}, 4'h3);
    chk("R2", "rx idle", {3'b0, rx_data}, 4'h1);
    @(negedge clk); port_latch = 2'b10; pad_i = 2'b10;
    edge1();
    chk("R2", "pad_o latch 10", {2'b0, pad_o}, 4'h2);
    chk("R2", "pad_rd after one edge", {2'b0, pad_rd}, 4'h0);
    edge1();
    chk("R2", "pad_rd after two edges", {2'b0, pad_rd}, 4'h2);
  endtask

  task automatic t_half();
    @(negedge clk); serial_en = 1; loop_sel = 0; port_latch = 2'b10;
    tx_en = 1; tx_data = 1; pad_i = 2'b00;
    edge1();
    chk("R3", "pad_oe transmit", {2'b0, pad_oe}, 4'h3);
    chk("R3", "pad_o transmit", {2'b0, pad_o}, 4'h3);
    chk("R7", "pin0 ignores latch0=0", {3'b0, pad_o[0]}, 4'h1);
    @(negedge clk); tx_data = 0;
    edge1();
    chk("R3", "pad_o data 0", {2'b0, pad_o}, 4'h1);
    @(negedge clk); tx_en = 0; pad_i = 2'b10;
    edge1();
    chk("R3", "pad_oe receive", {2'b0, pad_oe}, 4'h1);
    chk("R3", "direction pin receive", {3'b0, pad_o[0]}, 4'h0);
    edge1();
    chk("R4", "rx from pin1 = 1", {3'b0, rx_data}, 4'h1);
    @(negedge clk); pad_i = 2'b01;
    edge2();
    chk("R4", "rx from pin1 = 0", {3'b0, rx_data}, 4'h0);
  endtask

  task automatic t_full();
    @(negedge clk); loop_sel = 1; port_latch = 2'b11; tx_en = 1; tx_data = 0; pad_i = 2'b00;
    edge1();
    chk("R5", "pad_oe", {2'b0, pad_oe}, 4'h2);
    chk("R5", "pad_o tx 0", {2'b0, pad_o}, 4'h0);
    @(negedge clk); tx_data = 1; port_latch = 2'b10 ^ 2'b01 ^ 2'b01 | 2'b10; pad_i = 2'b01;
    edge1();
    chk("R5", "pad_o tx 1", {2'b0, pad_o}, 4'h2);
    edge1();
    chk("R5", "rx from pin0 = 1", {3'b0, rx_data}, 4'h1);
    @(negedge clk); pad_i = 2'b10;
    edge2();
    chk("R5", "rx from pin0 = 0", {3'b0, rx_data}, 4'h0);
    @(negedge clk); port_latch = 2'b10;
    edge1();
    chk("R7", "latch0 cleared, full mode pins", {pad_oe, pad_o}, 4'hA);
  endtask

  task automatic t_diag();
    @(negedge clk); serial_en = 1; loop_sel = 1; port_latch = 2'b01; tx_data = 1; pad_i = 2'b00;
    edge1();
    chk("R6", "pad_oe", {2'b0, pad_oe}, 4'h2);
    chk("R6", "pad_o", {2'b0, pad_o}, 4'h0);
    chk("R6", "rx loop 1", {3'b0, rx_data}, 4'h1);
    @(negedge clk); tx_data = 0; pad_i = 2'b11;
    edge1();
    chk("R6", "rx loop 0", {3'b0, rx_data}, 4'h0);
    edge2();
    chk("R6", "pins ignored", {3'b0, rx_data}, 4'h0);
    @(negedge clk); loop_sel = 0; tx_data = 1;
    edge1();
    chk("R6", "diag with loop_sel=0", {pad_oe, pad_o}, 4'h8);
    chk("R6", "rx loop 1 again", {3'b0, rx_data}, 4'h1);
  endtask

  task automatic t_switch();
    @(negedge clk); port_latch = 2'b11; loop_sel = 0; tx_en = 1; tx_data = 1;
    #1;
    chk("R8", "held before edge", {pad_oe, pad_o}, 4'h8);
    edge1();
    chk("R8", "applied after edge", {pad_oe, pad_o}, 4'hF);
    @(negedge clk); serial_en = 0; port_latch = 2'b00;
    #1;
    chk("R8", "held before edge 2", {pad_oe, pad_o}, 4'hF);
    edge1();
    chk("R8", "port mode after edge", {pad_oe, pad_o}, 4'hC);
  endtask

  task automatic t_clk();
    @(negedge clk); clk_src_sel = 1; ck_pad_i = 1;
    edge1();
    chk("R9", "ext_clk after one edge", {3'b0, ext_clk}, 4'h0);
    edge1();
    chk("R9", "ext_clk after two edges", {3'b0, ext_clk}, 4'h1);
    @(negedge clk); clk_src_sel = 0;
    #1;
    chk("R9", "ext_clk deselected", {3'b0, ext_clk}, 4'h0);
    @(negedge clk); clk_src_sel = 1; ck_pad_i = 0;
    #1;
    chk("R9", "ext_clk reselected still high", {3'b0, ext_clk}, 4'h1);
    edge2();
    chk("R9", "ext_clk follows 0", {3'b0, ext_clk}, 4'h0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_gpio();
    t_half();
    t_full();
    t_diag();
    t_switch();
    t_clk();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule